// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the countdown timer that sits beside a processor's local interrupt controller. Software programs it through a small four-register port: a start count, a clock-divide code, and a vector entry that carries an 8-bit interrupt vector, a mask flag and a mode flag. A fourth, read-only register returns the live count. In one-shot mode the timer counts down once and requests a single interrupt. In periodic mode it reloads itself and requests an interrupt every period. Each request is a one-clock pulse on `irq_valid`, with the programmed vector on `irq_vector`.

Timing is defined by elapsed ticks. A tick is a fixed number of input clocks set by the divide code. Ticks are counted from the clock edge that captures a write to the start-count register. If the start count is C, the Nth tick falls on the edge N x 2^shift edges after that capture edge. A zero start count parks the timer. Masking suppresses the requests but does not stop the counting.

Top module: `local_timer`

## Requirements
- R1: While the mask flag (bit 16 of the vector entry) is 1, `irq_valid` stays 0. Counting continues while masked.
- R2: The divide code uses bits 3, 1 and 0 of a 4-bit field, read as v = {b3,b1,b0}. When v = 7 the shift is 0. For any other v the shift is v+1. A tick occurs every 2^shift clocks, counted from the edge that loads the start count. A new divide code applies to counting after that edge.
- R3: In periodic mode (bit 17 of the vector entry = 1), with a start count C > 0 and d elapsed ticks, the live count is C - (d mod (C+1)). An expiry occurs at every tick where d is a nonzero multiple of C+1.
- R4: In periodic mode with a start count of 0, no expiry ever occurs.
- R5: In one-shot mode (bit 17 = 0), the live count is C - d while d < C. From d = C onward it reads 0 and stays at 0.
- R6: In one-shot mode exactly one expiry occurs, at tick C+1. No further expiry occurs until the start count is written again.
- R7: Register selects are: 0 = start count, 1 = divide code (4 bits), 2 = vector entry (bits 7:0 vector, bit 16 mask, bit 17 periodic), 3 = live count. `rd_data` is registered and shows the register selected by `addr` one clock earlier. After reset the vector entry reads 0x10000, the other registers read 0, and the shift is 0, which means divide by 1 until a divide code is written.
- R8: A write of the start count restarts counting at the capture edge, and no request appears in the clock that follows it. Writes to the vector entry that change mask, mode or vector do not restart counting.
- R9: An expiry makes `irq_valid` high for exactly the one clock after the expiring tick edge. `irq_vector` then holds bits 7:0 of the vector entry.
- R10: Writing 0 to the start count stops the timer. The live count then reads 0 and no request is made in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register selected by `addr` |
| addr | input | 2 | Register select |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the previous `addr` |
| irq_valid | output | 1 | One-clock expiry request |
| irq_vector | output | 8 | Vector presented with the request |

## Verification
Several faults appear on the live-count readback within one tick of the start-count write: a prescaler that starts from the wrong phase, a bad divide decode, or a wrong reload value. The readback is then off by one count, or it changes on the wrong clock. A faulty one-shot done flag or a faulty periodic wrap shows up at tick C+1 or 2(C+1). There the bench expects exactly one request, or exactly one per period, on a known edge. The sweep covers every start count up to 5, both modes, both mask states and four divide ratios up to 64, so each divide alignment is checked on an exact clock.

// File: rtl/lt_pkg.sv
package lt_pkg;
  typedef enum logic [1:0] {
    SEL_INIT = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_LVT  = 2'd2,
    SEL_CUR  = 2'd3
  } sel_e;

  localparam int VEC_LSB  = 0;
  localparam int MASK_BIT = 16;
  localparam int PER_BIT  = 17;

  // {b3,b1,b0} == 7 -> shift 0, otherwise shift v+1 (modulo 8)
  function automatic logic [2:0] shift_decode(input logic [3:0] code);
    logic [2:0] v;
    v = {code[3], code[1], code[0]};
    return (v == 3'd7) ? 3'd0 : v + 3'd1;
  endfunction
endpackage

// File: rtl/lt_prescale.sv
module lt_prescale #(
  parameter int SH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            run,
  input  logic [SH_W-1:0] shift,
  output logic            tick
);
  localparam int PS_W = (1 << SH_W) - 1;

  logic [PS_W-1:0] pc_q;
  logic [PS_W:0]   lim_w;

  always_comb begin
    lim_w = ({{PS_W{1'b0}}, 1'b1} << shift) - {{PS_W{1'b0}}, 1'b1};
    tick  = run && (pc_q == lim_w[PS_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) pc_q <= '0;
    else if (run)     pc_q <= tick ? '0 : pc_q + {{(PS_W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/lt_count.sv
module lt_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] ic,
  input  logic             periodic,
  input  logic             tick,
  output logic [CNT_W-1:0] cur,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic done_q;
  logic armed;

  always_comb begin
    armed  = (ic != '0);
    expire = tick && armed && !load && (cur == '0) && (periodic || !done_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= '0;
      done_q <= 1'b0;
    end else if (load) begin
      cur    <= load_val;
      done_q <= 1'b0;
    end else if (tick && armed) begin
      if (cur != '0)    cur <= cur - ONE;
      else if (periodic) begin
        cur    <= ic;
        done_q <= 1'b0;
      end else          done_q <= 1'b1;
    end
  end

  AST_CUR_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    cur <= ic); // R5
  AST_ONESHOT_HELD_ZERO: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (cur == '0)); // R6
endmodule

// File: rtl/local_timer.sv
module local_timer #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8,
  parameter int DIV_W = 4,
  parameter int SH_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector
);
  import lt_pkg::*;

  logic [CNT_W-1:0] ic_q;
  logic [DIV_W-1:0] div_q;
  logic [SH_W-1:0]  shift_q;
  logic [VEC_W-1:0] vec_q;
  logic             mask_q, per_q;
  logic             load, tick, expire;
  logic [CNT_W-1:0] cur, lvt_word;
  sel_e             sel;

  always_comb begin
    sel  = sel_e'(addr);
    load = wr_en && (sel == SEL_INIT);
    lvt_word = '0;
    lvt_word[VEC_LSB +: VEC_W] = vec_q;
    lvt_word[MASK_BIT] = mask_q;
    lvt_word[PER_BIT]  = per_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ic_q    <= '0;
      div_q   <= '0;
      shift_q <= '0;
      vec_q   <= '0;
      mask_q  <= 1'b1;
      per_q   <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        SEL_INIT: ic_q <= wr_data;
        SEL_DIV: begin
          div_q   <= wr_data[DIV_W-1:0];
          shift_q <= SH_W'(shift_decode(wr_data[3:0]));
        end
        SEL_LVT: begin
          vec_q  <= wr_data[VEC_LSB +: VEC_W];
          mask_q <= wr_data[MASK_BIT];
          per_q  <= wr_data[PER_BIT];
        end
        default: ;
      endcase
    end
  end

  lt_prescale #(.SH_W(SH_W)) u_ps (
    .clk(clk), .rst(rst), .clear(load), .run(ic_q != '0 || load),
    .shift(shift_q), .tick(tick)
  );

  lt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(wr_data), .ic(ic_q),
    .periodic(per_q), .tick(tick), .cur(cur), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data    <= '0;
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      case (sel)
        SEL_INIT: rd_data <= ic_q;
        SEL_DIV:  rd_data <= {{(CNT_W-DIV_W){1'b0}}, div_q};
        SEL_LVT:  rd_data <= lvt_word;
        default:  rd_data <= cur;
      endcase
      irq_valid <= expire && !mask_q;
      if (expire && !mask_q) irq_vector <= vec_q;
    end
  end

  AST_MASK_SILENT: assert property (@(posedge clk) disable iff (rst)
    mask_q |=> !irq_valid); // R1
  AST_ZERO_IC_SILENT: assert property (@(posedge clk) disable iff (rst)
    (ic_q == '0) |=> !irq_valid); // R4
  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    load |=> !irq_valid); // R8
endmodule

// File: tb/tb_local_timer.sv
module tb_local_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd3;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int n_cmp = 0, n_bad = 0;
  int edge_cnt = 0, load_edge = 0;
  int m_ic = 0, m_div = 1, m_per = 0, m_mask = 1, m_vec = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edge_cnt = edge_cnt + 1;

  local_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  task automatic chk(input string tag, input longint got, input longint exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, got, exp, edge_cnt);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic int div_of(input logic [3:0] c);
    int v;
    v = {c[3], c[1], c[0]};
    return (v == 7) ? 1 : (1 << (v + 1));
  endfunction

  function automatic int exp_cur(input int d);
    if (m_ic == 0) return 0;
    if (m_per != 0) return m_ic - (d % (m_ic + 1));
    return (d >= m_ic) ? 0 : m_ic - d;
  endfunction

  function automatic bit exp_fire(input int k);
    int d;
    if (k <= 0 || (k % m_div) != 0 || m_ic == 0 || m_mask != 0) return 1'b0;
    d = k / m_div;
    if (m_per != 0) return (d % (m_ic + 1)) == 0;
    return d == m_ic + 1;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    #1;
    if (a == 2'd0) load_edge = edge_cnt;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] a, input longint exp, input string tag);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    @(negedge clk);
    chk(tag, rd_data, exp);
    addr = 2'd3;
  endtask

  task automatic set_lvt(input int per, input int mask, input int vec);
    wr(2'd2, (32'(per) << 17) | (32'(mask) << 16) | 32'(vec & 8'hFF));
    m_per = per; m_mask = mask; m_vec = vec & 8'hFF;
  endtask

  task automatic watch(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      int k, d;
      bit f;
      @(posedge clk);
      @(negedge clk);
      k = edge_cnt - load_edge;
      d = (k - 1) / m_div;
      f = exp_fire(k);
      if (m_ic == 0) chk("R10 stopped count", rd_data, 0);
      else if (m_per != 0) chk("R3/R2 periodic count", rd_data, exp_cur(d));
      else chk("R5/R2 one-shot count", rd_data, exp_cur(d));
      if (m_mask != 0) chk("R1 masked irq", irq_valid, 0);
      else if (m_ic == 0 && m_per != 0) chk("R4 zero periodic irq", irq_valid, 0);
      else if (m_ic == 0) chk("R10 stopped irq", irq_valid, 0);
      else if (m_per != 0) chk("R3 periodic irq", irq_valid, f);
      else chk("R6 one-shot irq", irq_valid, f);
      if (f && irq_valid) chk("R9 irq vector", irq_vector, m_vec);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [3:0] codes [4];
    codes[0] = 4'hB; codes[1] = 4'h0; codes[2] = 4'h2; codes[3] = 4'h9;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R7 reset irq", irq_valid, 0);
    rd(2'd0, 0, "R7 reset start count");
    rd(2'd1, 0, "R7 reset divide");
    rd(2'd2, 32'h10000, "R7 reset vector entry");
    rd(2'd3, 0, "R7 reset live count");

    // reset shift is 0: divide by 1 before any divide write
    m_div = 1;
    set_lvt(0, 0, 8'h33);
    m_ic = 4; wr(2'd0, 4);
    watch(10);
    rd(2'd2, 32'h33, "R7 vector entry readback");
    rd(2'd0, 4, "R7 start count readback");

    foreach (codes[ci]) begin
      wr(2'd1, {28'd0, codes[ci]});
      m_div = div_of(codes[ci]);
      rd(2'd1, codes[ci], "R7/R2 divide readback");
      for (int per = 0; per < 2; per++)
        for (int mask = 0; mask < 2; mask++)
          for (int ic = 0; ic < 6; ic++) begin
            set_lvt(per, mask, 8'h40 + ic + 8 * per + 16 * mask);
            m_ic = ic; wr(2'd0, ic);
            watch((2 * (ic + 1) + 1) * m_div + 2);
          end
    end

    // R8: mask and vector changes do not restart counting
    wr(2'd1, 32'hB); m_div = 1;
    set_lvt(1, 0, 8'h5A);
    m_ic = 5; wr(2'd0, 5);
    watch(4);
    set_lvt(1, 1, 8'h5A);
    watch(9);
    set_lvt(1, 0, 8'h6B);
    watch(14);
    // R10: writing zero stops the timer
    m_ic = 0; wr(2'd0, 0);
    watch(8);
    // R8: a new start count restarts from its write
    m_ic = 2; wr(2'd0, 2);
    watch(10);

    report();
    $finish;
  end
endmodule